// File: doc/BRIEF.md
# UART Byte Buffering Register Front End

This block is the buffering layer of a UART, placed between a small CPU bus (3-bit address, read strobe, write strobe, 8-bit data) and the serial line. Received bytes collect in a receive queue that the CPU drains by repeated reads of one data offset. Bytes the CPU writes to the same offset collect in a transmit queue, from which a built-in serializer sends them. A status offset reports unread data, lost data, an empty transmit queue and a fully idle transmitter.

Two buffering modes exist. In queued mode each direction holds up to 16 bytes. In single-byte mode each direction holds exactly one byte. A control offset picks the mode and can discard either queue. The serial side uses a baud tick that the bench or a divider supplies. Each bit lasts 16 ticks. A frame has one low start bit, eight data bits with the least significant bit first, and one high stop bit.

Top module: `uart_fifo_front`

## Requirements
- R1: In queued mode (control bit 0 set) each direction stores up to 16 bytes. A 17th received byte that arrives while 16 are unread is lost.
- R2: A read strobe at offset 0 returns the oldest unread received byte. Later reads return later bytes in arrival order. A read while nothing is unread changes no state.
- R3: Status bit 0 is 1 while any received byte is unread. It is 0 from the cycle after the read that takes the last one.
- R4: In single-byte mode (control bit 0 clear, the reset value) each direction holds one byte. A second received byte is lost, and a second write is dropped while the first one still waits for the serializer.
- R5: Status bit 5 is 1 exactly when the transmit storage is empty. Several writes may follow it, and no register shows the fill level.
- R6: Status bit 6 is 1 exactly when the transmit storage is empty and no frame is being sent.
- R7: A received byte that finds its storage full is discarded and sets status bit 1. A read of the status offset (5) clears bit 1, unless a new loss happens in the same cycle.
- R8: A write to offset 0 while the transmit storage is full is ignored and does not disturb the stored bytes.
- R9: A write to the control offset (2) whose bit 0 differs from the current mode switches the mode and empties both directions.
- R10: Control bit 1 empties the receive storage and control bit 2 empties the transmit storage. Neither bit is stored. A frame already being sent completes.
- R11: The serial output idles high. It sends a low start bit, eight data bits with the least significant first, and a high stop bit, each 16 baud ticks long. The next stored byte starts with no gap after the stop bit.
- R12: The receiver synchronizes the line with two flops. It starts on the first tick that sees the line low and rechecks it at tick 8, aborting if the line is high. It samples each data bit and the stop bit 16 ticks apart and keeps the byte only when the stop bit is high.
- R13: After reset the status reads 0x60, the mode is single-byte and the serial output is high.
- R14: The status register sits at offset 5 with bits 2, 3, 4 and 7 at 0. Offsets other than 0 and 5 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 3 | Register offset |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset, combinational |
| baud_tick | input | 1 | One-cycle pulse, 16 per bit period |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input, asynchronous |

## Verification
Every strobe takes effect on the clock edge where it is sampled. The read data and status for the new state are therefore valid in the following cycle. A byte reaches the serializer on the first edge where the line is idle and the storage holds data, and its start bit is on the line one cycle later. A received byte becomes readable one cycle after the tick that samples its stop bit, which is tick 152 counted from the start-detecting tick. That tick sees the line two clocks after the line falls. The bench keeps a behavioural queue model that steps on the same edges and compares the serial output and the visible register on every falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/uart_fifo_front.sv
module uart_fifo_front #(
  parameter int DEPTH = 16,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_rd,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       baud_tick,
  output logic       txd,
  input  logic       rxd
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int PW = $clog2(DEPTH);
  localparam int TW = $clog2(OVS);
  localparam logic [2:0] A_DATA = 3'd0;
  localparam logic [2:0] A_CTRL = 3'd2;
  localparam logic [2:0] A_STAT = 3'd5;
  localparam logic [TW-1:0] T_LAST = TW'(OVS - 1);
  localparam logic [TW-1:0] T_MID  = TW'(OVS / 2 - 1);
  localparam logic [3:0] B_STOP = 4'd9;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  logic          fifo_en;
  logic [CW-1:0] lim;
  assign lim = fifo_en ? CW'(DEPTH) : CW'(1);

  logic ctl_wr, mode_chg, rx_flush, tx_flush, thr_wr, rbr_rd, lsr_rd, ctl_unused;
  assign ctl_wr     = bus_wr && bus_addr == A_CTRL;
  assign mode_chg   = ctl_wr && (bus_wdata[0] != fifo_en);
  assign rx_flush   = ctl_wr && (bus_wdata[1] || mode_chg);
  assign tx_flush   = ctl_wr && (bus_wdata[2] || mode_chg);
  assign thr_wr     = bus_wr && bus_addr == A_DATA;
  assign rbr_rd     = bus_rd && bus_addr == A_DATA;
  assign lsr_rd     = bus_rd && bus_addr == A_STAT;
  assign ctl_unused = ^bus_wdata[7:3];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) fifo_en <= 1'b0;
    else if (ctl_wr) fifo_en <= bus_wdata[0];

  // ---------------- receive path ----------------
  logic [1:0] rx_sync;
  logic       rxd_s;
  assign rxd_s = rx_sync[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rx_sync <= 2'b11;
    else rx_sync <= {rx_sync[0], rxd};

  logic          rx_busy;
  logic [TW-1:0] rx_t;
  logic [3:0]    rx_b;
  logic [7:0]    rx_sh;
  logic          rx_done, rx_push, rx_full, rx_keep, rx_pop, overrun;
  logic [CW-1:0] rx_cnt;
  logic [PW-1:0] rx_wp, rx_rp;
  logic [7:0]    rx_mem [DEPTH];

  assign rx_done = rx_busy && baud_tick && rx_t == T_MID && rx_b == B_STOP;
  assign rx_push = rx_done && rxd_s && !rx_flush;
  assign rx_full = rx_cnt >= lim;
  assign rx_keep = rx_push && !rx_full;
  assign rx_pop  = rbr_rd && rx_cnt != '0 && !rx_flush;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_busy <= 1'b0;
      rx_t    <= '0;
      rx_b    <= '0;
      rx_sh   <= '0;
    end else if (baud_tick) begin
      if (!rx_busy) begin
        if (!rxd_s) begin
          rx_busy <= 1'b1;
          rx_t    <= '0;
          rx_b    <= '0;
        end
      end else begin
        rx_t <= (rx_t == T_LAST) ? '0 : rx_t + TW'(1);
        if (rx_t == T_LAST) rx_b <= rx_b + 4'd1;
        if (rx_t == T_MID) begin
          if (rx_b == 4'd0) begin
            if (rxd_s) rx_busy <= 1'b0;
          end else if (rx_b == B_STOP) rx_busy <= 1'b0;
          else rx_sh <= {rxd_s, rx_sh[7:1]};
        end
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_cnt <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
    end else if (rx_flush) begin
      rx_cnt <= '0;
      rx_wp  <= '0;
      rx_rp  <= '0;
    end else begin
      if (rx_keep) rx_wp <= bump(rx_wp);
      if (rx_pop) rx_rp <= bump(rx_rp);
      rx_cnt <= rx_cnt + CW'(rx_keep) - CW'(rx_pop);
    end

  always_ff @(posedge clk)
    if (rx_keep) rx_mem[rx_wp] <= rx_sh;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) overrun <= 1'b0;
    else if (rx_push && rx_full) overrun <= 1'b1;
    else if (lsr_rd) overrun <= 1'b0;

  // ---------------- transmit path ----------------
  logic          tx_busy;
  logic [TW-1:0] tx_t;
  logic [3:0]    tx_b;
  logic [9:0]    tx_sh;
  logic          tx_end, tx_pop, tx_keep;
  logic [CW-1:0] tx_cnt;
  logic [PW-1:0] tx_wp, tx_rp;
  logic [7:0]    tx_mem [DEPTH];

  assign tx_end  = tx_busy && baud_tick && tx_t == T_LAST && tx_b == B_STOP;
  assign tx_pop  = (!tx_busy || tx_end) && tx_cnt != '0 && !tx_flush;
  assign tx_keep = thr_wr && tx_cnt < lim;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_cnt <= '0;
      tx_wp  <= '0;
      tx_rp  <= '0;
    end else if (tx_flush) begin
      tx_cnt <= '0;
      tx_wp  <= '0;
      tx_rp  <= '0;
    end else begin
      if (tx_keep) tx_wp <= bump(tx_wp);
      if (tx_pop) tx_rp <= bump(tx_rp);
      tx_cnt <= tx_cnt + CW'(tx_keep) - CW'(tx_pop);
    end

  always_ff @(posedge clk)
    if (tx_keep) tx_mem[tx_wp] <= bus_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_busy <= 1'b0;
      tx_t    <= '0;
      tx_b    <= '0;
      tx_sh   <= '1;
    end else if (tx_pop) begin
      tx_busy <= 1'b1;
      tx_t    <= '0;
      tx_b    <= '0;
      tx_sh   <= {1'b1, tx_mem[tx_rp], 1'b0};
    end else if (tx_end) begin
      tx_busy <= 1'b0;
    end else if (tx_busy && baud_tick) begin
      if (tx_t == T_LAST) begin
        tx_t  <= '0;
        tx_b  <= tx_b + 4'd1;
        tx_sh <= {1'b1, tx_sh[9:1]};
      end else begin
        tx_t <= tx_t + TW'(1);
      end
    end

  assign txd = tx_busy ? tx_sh[0] : 1'b1;

  // ---------------- register view ----------------
  logic [7:0] lsr;
  assign lsr = {1'b0, (tx_cnt == '0) && !tx_busy, tx_cnt == '0, 3'b000, overrun, rx_cnt != '0};

  always_comb
    case (bus_addr)
      A_DATA:  bus_rdata = rx_mem[rx_rp];
      A_STAT:  bus_rdata = lsr;
      default: bus_rdata = 8'h00;
    endcase

  // ---------------- assertions ----------------
  assert_depth_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cnt <= lim) && (tx_cnt <= lim));
  assert_last_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rbr_rd && rx_cnt == CW'(1) && !rx_push) |=> !lsr[0]);
  assert_temt_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_end && tx_cnt == '0 && !thr_wr) |=> lsr[6]);
  assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full) |=> lsr[1]);
  assert_full_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && tx_cnt == lim) |=> tx_cnt <= $past(tx_cnt));
  assert_mode_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (rx_cnt == '0) && (tx_cnt == '0));
  assert_start_bit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop |=> !txd);
endmodule

// File: tb/test_uart_fifo_front.sv
`timescale 1ns/1ps
module test_uart_fifo_front;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [2:0] bus_addr = 3'd5;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       baud_tick = 1'b0;
  logic       txd;
  logic       rxd = 1'b1;

  uart_fifo_front i_uart_fifo_front (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .baud_tick(baud_tick), .txd(txd), .rxd(rxd)
  );

  always #2 clk = ~clk;

  int checks = 0, errors = 0, tcnt = 0;
  bit finished = 0;
  string tx_tag = "R11";

  // behavioural model
  logic [7:0] q_rx[$], q_tx[$];
  bit m_fen = 0, m_oe = 0, t_busy = 0, r_pend = 0, r_stop = 1;
  int t_cnt = 0, r_idx = 0;
  logic [7:0] t_cur = 8'h00, r_byte = 8'h00;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic exp_txd();
    int idx;
    if (!t_busy) return 1'b1;
    idx = t_cnt / 16;
    if (idx == 0) return 1'b0;
    if (idx == 9) return 1'b1;
    return t_cur[idx-1];
  endfunction

  function automatic logic [7:0] exp_lsr();
    logic thre;
    thre = (q_tx.size() == 0);
    return {1'b0, thre && !t_busy, thre, 3'b000, m_oe, q_rx.size() != 0};
  endfunction

  initial forever begin
    @(posedge clk); #1;
    tcnt = (tcnt + 1) % 4;
    baud_tick = (tcnt == 0);
  end

  always @(posedge clk) begin : model
    bit ctl, flt, flr, thr, popt, pusht, tend, rdone, pushr, popr, fullr, lsrrd;
    int lim;
    if (!rst_n) begin
      q_rx.delete(); q_tx.delete();
      m_fen = 0; m_oe = 0; t_busy = 0; t_cnt = 0;
    end else begin
      lim   = m_fen ? 16 : 1;
      ctl   = bus_wr && bus_addr == 3'd2;
      flt   = ctl && (bus_wdata[2] || bus_wdata[0] != m_fen);
      flr   = ctl && (bus_wdata[1] || bus_wdata[0] != m_fen);
      thr   = bus_wr && bus_addr == 3'd0;
      lsrrd = bus_rd && bus_addr == 3'd5;
      tend  = t_busy && baud_tick && t_cnt == 159;
      popt  = !flt && q_tx.size() > 0 && (!t_busy || tend);
      pusht = thr && q_tx.size() < lim;
      rdone = 0;
      if (r_pend && baud_tick) begin
        r_idx++;
        if (r_idx == 152) begin rdone = 1; r_pend = 0; end
      end
      pushr = rdone && r_stop && !flr;
      popr  = !flr && bus_rd && bus_addr == 3'd0 && q_rx.size() > 0;
      fullr = q_rx.size() >= lim;
      if (pushr && fullr) m_oe = 1;
      else if (lsrrd) m_oe = 0;
      if (t_busy && baud_tick && !tend) t_cnt++;
      if (tend && !popt) t_busy = 0;
      if (popt) begin t_busy = 1; t_cnt = 0; t_cur = q_tx[0]; end
      if (flt) q_tx.delete();
      else begin
        if (popt) void'(q_tx.pop_front());
        if (pusht) q_tx.push_back(bus_wdata);
      end
      if (flr) q_rx.delete();
      else begin
        if (popr) void'(q_rx.pop_front());
        if (pushr && !fullr) q_rx.push_back(r_byte);
      end
      if (ctl) m_fen = bus_wdata[0];
    end
  end

  always @(negedge clk) begin : compare
    logic [7:0] e;
    if (rst_n && !finished) begin
      chk(txd === exp_txd(), tx_tag, "txd", int'(txd), int'(exp_txd()));
      if (bus_addr == 3'd5) begin
        e = exp_lsr();
        chk(bus_rdata[0] === e[0], "R3", "status bit0", int'(bus_rdata[0]), int'(e[0]));
        chk(bus_rdata[1] === e[1], "R7", "status bit1", int'(bus_rdata[1]), int'(e[1]));
        chk(bus_rdata[5] === e[5], "R5", "status bit5", int'(bus_rdata[5]), int'(e[5]));
        chk(bus_rdata[6] === e[6], "R6", "status bit6", int'(bus_rdata[6]), int'(e[6]));
        chk((bus_rdata & 8'h9C) === 8'h00, "R14", "status spare bits", int'(bus_rdata), int'(e));
      end else if (bus_addr == 3'd0 && q_rx.size() > 0) begin
        chk(bus_rdata === q_rx[0], "R2", "receive data", int'(bus_rdata), int'(q_rx[0]));
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_addr = 3'd5;
  endtask

  task automatic wr_burst(input int n, input logic [7:0] base);
    @(posedge clk); #1;
    bus_addr = 3'd0; bus_wr = 1'b1;
    for (int i = 0; i < n; i++) begin
      bus_wdata = base + 8'(i);
      @(posedge clk); #1;
    end
    bus_wr = 1'b0; bus_addr = 3'd5;
  endtask

  task automatic rd(input logic [2:0] a);
    @(posedge clk); #1;
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0; bus_addr = 3'd5;
  endtask

  task automatic ticks(input int n);
    repeat (n) begin
      @(posedge clk);
      while (!baud_tick) @(posedge clk);
    end
    #1;
  endtask

  task automatic send(input logic [7:0] b, input bit stop_ok);
    ticks(1);
    rxd = 1'b0; r_byte = b; r_stop = stop_ok; r_idx = -1; r_pend = 1;
    ticks(16);
    for (int i = 0; i < 8; i++) begin
      rxd = b[i];
      ticks(16);
    end
    rxd = stop_ok;
    ticks(16);
    rxd = 1'b1;
    ticks(4);
  endtask

  task automatic stat_is(input logic [7:0] mask, input logic [7:0] val, input string req, input string what);
    @(negedge clk);
    chk((bus_rdata & mask) === val, req, what, int'(bus_rdata & mask), int'(val));
  endtask

  task automatic summary();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R11 watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    // R13 reset state
    stat_is(8'hFF, 8'h60, "R13", "status after reset");
    chk(txd === 1'b1, "R13", "line after reset", int'(txd), 1);
    // R14 unused offsets read zero
    @(posedge clk); #1 bus_addr = 3'd3;
    @(negedge clk); chk(bus_rdata === 8'h00, "R14", "offset 3", int'(bus_rdata), 0);
    @(posedge clk); #1 bus_addr = 3'd2;
    @(negedge clk); chk(bus_rdata === 8'h00, "R14", "offset 2", int'(bus_rdata), 0);
    @(posedge clk); #1 bus_addr = 3'd5;

    // R4 single-byte mode, transmit: third write dropped
    tx_tag = "R4";
    wr(3'd0, 8'hA5);
    wr(3'd0, 8'h3C);
    wr(3'd0, 8'h77);
    stat_is(8'h20, 8'h00, "R4", "holding byte occupied");
    ticks(340);
    stat_is(8'h60, 8'h60, "R6", "transmitter idle");
    // R4 single-byte mode, receive: second byte lost
    send(8'h11, 1);
    send(8'h22, 1);
    stat_is(8'h03, 8'h03, "R4", "second byte overruns");
    rd(3'd5);
    stat_is(8'h02, 8'h00, "R7", "overrun cleared by status read");
    rd(3'd0);
    stat_is(8'h01, 8'h00, "R3", "data ready after last read");

    // R9 switch to queued mode; R8 burst of 18 writes
    tx_tag = "R8";
    wr(3'd2, 8'h01);
    wr_burst(18, 8'h40);
    stat_is(8'h20, 8'h00, "R5", "queue holds data");
    // R1 receive depth
    for (int i = 0; i < 16; i++) send(8'h80 + 8'(i), 1);
    stat_is(8'h03, 8'h01, "R1", "16 bytes stored without loss");
    send(8'hEE, 1);
    stat_is(8'h02, 8'h02, "R1", "17th byte lost");
    rd(3'd5);
    for (int i = 0; i < 16; i++) rd(3'd0);
    stat_is(8'h01, 8'h00, "R3", "queue drained");
    rd(3'd0);
    stat_is(8'h03, 8'h00, "R2", "empty read has no effect");
    ticks(160 * 2 + 20);
    stat_is(8'h60, 8'h60, "R6", "all frames sent");

    // R12 bad stop bit and glitch
    tx_tag = "R11";
    send(8'h5A, 0);
    stat_is(8'h01, 8'h00, "R12", "bad stop discarded");
    ticks(1); rxd = 1'b0; ticks(4); rxd = 1'b1; ticks(20);
    stat_is(8'h01, 8'h00, "R12", "short glitch ignored");
    send(8'hC3, 1);
    stat_is(8'h01, 8'h01, "R12", "good frame kept");
    rd(3'd0);

    // R10 flush bits while a frame is in flight
    tx_tag = "R10";
    send(8'h12, 1);
    send(8'h34, 1);
    wr_burst(3, 8'h90);
    wr(3'd2, 8'h07);
    stat_is(8'h21, 8'h20, "R10", "both queues emptied");
    ticks(200);
    stat_is(8'h60, 8'h60, "R10", "in-flight frame completed");

    // R9 mode change empties receive side
    tx_tag = "R9";
    send(8'h66, 1);
    wr(3'd2, 8'h00);
    stat_is(8'h01, 8'h00, "R9", "mode change flush");
    send(8'h67, 1);
    stat_is(8'h01, 8'h01, "R9", "single-byte mode receives");
    rd(3'd0);
    ticks(10);
    summary();
  end
endmodule